// File: doc/BRIEF.md
# Thread Block Admission Controller

This block sits in front of one compute multiprocessor and decides, one request at a time, whether an incoming thread block can become resident there. Each request states how many threads the block has, how many registers each of its threads needs and how many bytes of on-chip shared storage it wants. The controller keeps running totals for four separate pools: resident block slots, resident threads, registers and shared-storage bytes. A request is granted only when every pool still stays within its limit after the new block is added.

A granted block receives a slot number, returned with the grant. When the block finishes, the upstream logic presents that slot number on the completion port and the controller gives back exactly what was charged at grant time. Requests that do not fit yet are held at the head of the stream with grant low until a completion frees enough room. Requests that could never fit, even on an empty multiprocessor, are flagged and dropped so the stream cannot lock up. A resident-block count is reported at all times.

Top module: `blk_admit`

## Requirements
- R1: At most 8 blocks are resident; while 8 are resident, no request is granted, and a request that fits all other pools waits with grant low.
- R2: The sum of threads over resident blocks never exceeds 768; a block that brings the total to exactly 768 is granted, one that would pass it waits.
- R3: A block is charged registers-per-thread times its thread count against a pool of 8192; with 256-thread blocks, 3 blocks fit at 10 registers per thread and only 2 at 11.
- R4: The shared-storage pool holds 16384 bytes; each resident block is charged its requested byte count, and a request that would pass the total waits.
- R5: A request that fits is granted in the same cycle it is presented (`req_grant` high while `req_valid` is high), and `grant_slot` names the lowest-numbered free slot (0 to 7).
- R6: A request that does not fit keeps `req_grant` and `req_reject` low for as long as it is held, and is granted once a completion has freed enough resources.
- R7: A request with 0 threads, more than 512 threads, a register demand above 8192 or a byte demand above 16384 raises `req_reject` for that cycle, is never granted, and takes no resources.
- R8: A completion on a resident slot frees that slot's threads, registers and bytes; the freed room becomes usable the cycle after the completion; a completion naming a free slot changes nothing.
- R9: `occupancy` equals the number of resident blocks and changes on the clock edge that accepts a grant or a completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, empties all pools |
| req_valid | input | 1 | A block request is presented |
| req_threads | input | 10 | Threads in the requested block |
| req_regs_per_thread | input | 6 | Registers needed by each thread |
| req_smem_bytes | input | 15 | Shared-storage bytes requested |
| req_grant | output | 1 | Request accepted this cycle |
| req_reject | output | 1 | Request can never fit; dropped this cycle |
| grant_slot | output | 3 | Slot assigned to the granted block |
| done_valid | input | 1 | A resident block has completed |
| done_slot | input | 3 | Slot of the completed block |
| occupancy | output | 4 | Number of resident blocks |

## Verification
The hardest case to reach is a held request whose missing room is freed by a completion in the very cycle it is being examined: the grant must stay low in that cycle and rise in the next, on the slot just released. The bench fills the register pool with two 11-register blocks so that a third stalls only on registers, then presents the completion for slot 0 on the same clock as the stalled request and samples the grant before and after that edge. Pool limits are each isolated by choosing requests that leave the other three pools with headroom.

// File: rtl/blk_admit_pkg.sv
package blk_admit_pkg;
   typedef enum logic [1:0] {
      V_IDLE   = 2'd0,
      V_GRANT  = 2'd1,
      V_STALL  = 2'd2,
      V_REJECT = 2'd3
   } verdict_t;
endpackage

// File: rtl/admit_demand.sv
module admit_demand #(
   parameter int MAX_BLK_THREADS = 512,
   parameter int REG_POOL        = 8192,
   parameter int SMEM_BYTES      = 16384,
   parameter int TW              = 10,
   parameter int RPT_W           = 6,
   parameter int SW              = 15,
   parameter int RW              = 14
) (
   input  logic [TW-1:0]    threads,
   input  logic [RPT_W-1:0] regs_per_thread,
   input  logic [SW-1:0]    smem_bytes,
   output logic             impossible,
   output logic [RW-1:0]    reg_need
);
   localparam int PW = TW + RPT_W;
   localparam logic [TW-1:0] THR_LIM  = TW'(MAX_BLK_THREADS);
   localparam logic [PW-1:0] REG_LIM  = PW'(REG_POOL);
   localparam logic [SW-1:0] SMEM_LIM = SW'(SMEM_BYTES);

   logic [PW-1:0] product;

   always_comb begin
      product    = PW'(threads) * PW'(regs_per_thread);
      reg_need   = product[RW-1:0];
      impossible = (threads == '0) || (threads > THR_LIM) ||
                   (product > REG_LIM) || (smem_bytes > SMEM_LIM);
   end
endmodule

// File: rtl/admit_pool.sv
module admit_pool #(
   parameter int LIMIT = 768,
   parameter int W     = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] need,
   input  logic         add_en,
   input  logic         sub_en,
   input  logic [W-1:0] sub_amt,
   output logic         fits,
   output logic [W-1:0] used
);
   localparam logic [W:0] LIM = (W+1)'(LIMIT);

   logic [W-1:0] used_q;

   assign used = used_q;
   assign fits = ({1'b0, used_q} + {1'b0, need}) <= LIM;

   always_ff @(posedge clk) begin
      if (!rst_n)
         used_q <= '0;
      else
         used_q <= used_q + (add_en ? need : '0) - (sub_en ? sub_amt : '0);
   end
endmodule

// File: rtl/admit_slot_table.sv
module admit_slot_table #(
   parameter int NSLOT = 8,
   parameter int TW    = 10,
   parameter int RW    = 14,
   parameter int SW    = 15,
   parameter int SLW   = 3,
   parameter int OW    = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           alloc_en,
   input  logic [TW-1:0]  alloc_thr,
   input  logic [RW-1:0]  alloc_reg,
   input  logic [SW-1:0]  alloc_smem,
   input  logic           rel_req,
   input  logic [SLW-1:0] rel_slot,
   output logic           free_ok,
   output logic [SLW-1:0] free_idx,
   output logic           rel_en,
   output logic [TW-1:0]  rel_thr,
   output logic [RW-1:0]  rel_reg,
   output logic [SW-1:0]  rel_smem,
   output logic [OW-1:0]  occ
);
   logic [NSLOT-1:0] live_q;
   logic [TW-1:0]    thr_q  [NSLOT];
   logic [RW-1:0]    reg_q  [NSLOT];
   logic [SW-1:0]    smem_q [NSLOT];

   always_comb begin
      free_ok  = 1'b0;
      free_idx = '0;
      occ      = '0;
      for (int i = NSLOT - 1; i >= 0; i--) begin
         if (!live_q[i]) begin
            free_ok  = 1'b1;
            free_idx = SLW'(i);
         end
      end
      for (int i = 0; i < NSLOT; i++)
         occ = occ + OW'(live_q[i]);
   end

   always_comb begin
      rel_en   = 1'b0;
      rel_thr  = '0;
      rel_reg  = '0;
      rel_smem = '0;
      if (rel_req && (int'(rel_slot) < NSLOT) && live_q[rel_slot]) begin
         rel_en   = 1'b1;
         rel_thr  = thr_q[rel_slot];
         rel_reg  = reg_q[rel_slot];
         rel_smem = smem_q[rel_slot];
      end
   end

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic take, drop;
      assign take = alloc_en && (free_idx == SLW'(s));
      assign drop = rel_en && (rel_slot == SLW'(s));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            live_q[s] <= 1'b0;
            thr_q[s]  <= '0;
            reg_q[s]  <= '0;
            smem_q[s] <= '0;
         end else if (take) begin
            live_q[s] <= 1'b1;
            thr_q[s]  <= alloc_thr;
            reg_q[s]  <= alloc_reg;
            smem_q[s] <= alloc_smem;
         end else if (drop) begin
            live_q[s] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/blk_admit.sv
module blk_admit #(
   parameter int MAX_BLOCKS      = 8,
   parameter int MAX_THREADS     = 768,
   parameter int MAX_BLK_THREADS = 512,
   parameter int REG_POOL        = 8192,
   parameter int SMEM_BYTES      = 16384,
   parameter int RPT_W           = 6,
   localparam int TW  = $clog2(MAX_BLK_THREADS + 2),
   localparam int SW  = $clog2(SMEM_BYTES + 2),
   localparam int SLW = (MAX_BLOCKS > 1) ? $clog2(MAX_BLOCKS) : 1,
   localparam int OW  = $clog2(MAX_BLOCKS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [TW-1:0]    req_threads,
   input  logic [RPT_W-1:0] req_regs_per_thread,
   input  logic [SW-1:0]    req_smem_bytes,
   output logic             req_grant,
   output logic             req_reject,
   output logic [SLW-1:0]   grant_slot,
   input  logic             done_valid,
   input  logic [SLW-1:0]   done_slot,
   output logic [OW-1:0]    occupancy
);
   import blk_admit_pkg::*;

   localparam int THW = $clog2(MAX_THREADS + 1);
   localparam int RW  = $clog2(REG_POOL + 1);

   if (MAX_BLK_THREADS > MAX_THREADS) begin : g_bad_thr
      $error("per-block thread limit exceeds resident thread limit");
   end
   if (MAX_BLOCKS < 1 || MAX_BLK_THREADS < 1) begin : g_bad_cnt
      $error("block and thread limits must be positive");
   end

   logic           impossible;
   logic [RW-1:0]  reg_need;
   logic           free_ok;
   logic           rel_en;
   logic [TW-1:0]  rel_thr;
   logic [RW-1:0]  rel_reg;
   logic [SW-1:0]  rel_smem;
   logic           fit_thr, fit_reg, fit_smem;
   logic [THW-1:0] thr_used;
   logic [RW-1:0]  reg_used;
   logic [SW-1:0]  smem_used;
   verdict_t       verdict;

   admit_demand #(
      .MAX_BLK_THREADS(MAX_BLK_THREADS), .REG_POOL(REG_POOL),
      .SMEM_BYTES(SMEM_BYTES), .TW(TW), .RPT_W(RPT_W), .SW(SW), .RW(RW)
   ) u_demand (
      .threads(req_threads), .regs_per_thread(req_regs_per_thread),
      .smem_bytes(req_smem_bytes), .impossible(impossible), .reg_need(reg_need)
   );

   always_comb begin
      if (!req_valid)
         verdict = V_IDLE;
      else if (impossible)
         verdict = V_REJECT;
      else if (free_ok && fit_thr && fit_reg && fit_smem)
         verdict = V_GRANT;
      else
         verdict = V_STALL;
   end

   assign req_grant  = (verdict == V_GRANT);
   assign req_reject = (verdict == V_REJECT);

   admit_slot_table #(
      .NSLOT(MAX_BLOCKS), .TW(TW), .RW(RW), .SW(SW), .SLW(SLW), .OW(OW)
   ) u_slots (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(req_grant), .alloc_thr(req_threads), .alloc_reg(reg_need),
      .alloc_smem(req_smem_bytes),
      .rel_req(done_valid), .rel_slot(done_slot),
      .free_ok(free_ok), .free_idx(grant_slot),
      .rel_en(rel_en), .rel_thr(rel_thr), .rel_reg(rel_reg), .rel_smem(rel_smem),
      .occ(occupancy)
   );

   admit_pool #(.LIMIT(MAX_THREADS), .W(THW)) u_thr_pool (
      .clk(clk), .rst_n(rst_n), .need(THW'(req_threads)),
      .add_en(req_grant), .sub_en(rel_en), .sub_amt(THW'(rel_thr)),
      .fits(fit_thr), .used(thr_used)
   );

   admit_pool #(.LIMIT(REG_POOL), .W(RW)) u_reg_pool (
      .clk(clk), .rst_n(rst_n), .need(reg_need),
      .add_en(req_grant), .sub_en(rel_en), .sub_amt(rel_reg),
      .fits(fit_reg), .used(reg_used)
   );

   admit_pool #(.LIMIT(SMEM_BYTES), .W(SW)) u_smem_pool (
      .clk(clk), .rst_n(rst_n), .need(req_smem_bytes),
      .add_en(req_grant), .sub_en(rel_en), .sub_amt(rel_smem),
      .fits(fit_smem), .used(smem_used)
   );
endmodule

// File: rtl/blk_admit_chk.sv
module blk_admit_chk #(
   parameter int MAX_BLOCKS  = 8,
   parameter int MAX_THREADS = 768,
   parameter int REG_POOL    = 8192,
   parameter int SMEM_BYTES  = 16384,
   parameter int THW         = 10,
   parameter int RW          = 14,
   parameter int SW          = 15,
   parameter int OW          = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           req_valid,
   input logic           req_grant,
   input logic           req_reject,
   input logic           done_valid,
   input logic [OW-1:0]  occupancy,
   input logic [THW-1:0] thr_used,
   input logic [RW-1:0]  reg_used,
   input logic [SW-1:0]  smem_used
);
   p_slot_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      int'(occupancy) <= MAX_BLOCKS);

   p_full_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(occupancy) == MAX_BLOCKS) |-> !req_grant);

   p_thread_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      int'(thr_used) <= MAX_THREADS);

   p_reg_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(reg_used) <= REG_POOL);

   p_smem_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(smem_used) <= SMEM_BYTES);

   p_grant_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_grant || req_reject) |-> req_valid);

   p_reject_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_grant && req_reject));

   p_reject_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_reject && !done_valid) |=> $stable(thr_used) && $stable(occupancy));

   p_occ_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_grant && !done_valid) |=> occupancy == $past(occupancy) + 1'b1);

   p_occ_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_grant && !done_valid) |=> $stable(occupancy));
endmodule

bind blk_admit blk_admit_chk #(
   .MAX_BLOCKS(MAX_BLOCKS), .MAX_THREADS(MAX_THREADS), .REG_POOL(REG_POOL),
   .SMEM_BYTES(SMEM_BYTES), .THW(THW), .RW(RW), .SW(SW), .OW(OW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_grant(req_grant),
   .req_reject(req_reject), .done_valid(done_valid), .occupancy(occupancy),
   .thr_used(thr_used), .reg_used(reg_used), .smem_used(smem_used)
);

// File: tb/blk_admit_test.sv
`timescale 1ns/1ps
module blk_admit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [9:0]  req_threads = '0;
   logic [5:0]  req_regs_per_thread = '0;
   logic [14:0] req_smem_bytes = '0;
   logic        req_grant, req_reject;
   logic [2:0]  grant_slot;
   logic        done_valid = 1'b0;
   logic [2:0]  done_slot = '0;
   logic [3:0]  occupancy;

   int checks = 0;
   int errors = 0;
   bit reported = 1'b0;

   always #10 clk = ~clk;

   blk_admit uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_threads(req_threads),
      .req_regs_per_thread(req_regs_per_thread), .req_smem_bytes(req_smem_bytes),
      .req_grant(req_grant), .req_reject(req_reject), .grant_slot(grant_slot),
      .done_valid(done_valid), .done_slot(done_slot), .occupancy(occupancy)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Present one request for one cycle and check the combinational answer.
   task automatic try_req(input string tag, input int thr, input int rpt, input int smem,
                          input int exp_g, input int exp_r, input int exp_slot);
      @(negedge clk);
      req_valid = 1'b1;
      req_threads = 10'(thr);
      req_regs_per_thread = 6'(rpt);
      req_smem_bytes = 15'(smem);
      #2;
      check({tag, " grant"}, int'(req_grant), exp_g);
      check({tag, " reject"}, int'(req_reject), exp_r);
      if (exp_g == 1) check({tag, " slot"}, int'(grant_slot), exp_slot);
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   task automatic release_slot(input int s);
      @(negedge clk);
      done_valid = 1'b1;
      done_slot = 3'(s);
      @(posedge clk);
      #1 done_valid = 1'b0;
   endtask

   task automatic clear_all();
      for (int s = 0; s < 8; s++) release_slot(s);
   endtask

   task automatic check_occ(input string tag, input int exp);
      @(negedge clk);
      check({tag, " occupancy"}, int'(occupancy), exp);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R9 reset occupancy", int'(occupancy), 0);
      check("R5 reset grant", int'(req_grant), 0);
      check("R7 reset reject", int'(req_reject), 0);
   endtask

   task automatic t_registers();
      try_req("R3 11rpt a", 256, 11, 0, 1, 0, 0);
      try_req("R3 11rpt b", 256, 11, 0, 1, 0, 1);
      try_req("R3 11rpt third stalls", 256, 11, 0, 0, 0, 0);
      check_occ("R9 after two", 2);
      clear_all();
      check_occ("R8 cleared", 0);
      try_req("R3 10rpt a", 256, 10, 0, 1, 0, 0);
      try_req("R3 10rpt b", 256, 10, 0, 1, 0, 1);
      try_req("R3 10rpt c", 256, 10, 0, 1, 0, 2);
      check_occ("R9 after three", 3);
      clear_all();
   endtask

   task automatic t_threads();
      try_req("R2 512", 512, 1, 0, 1, 0, 0);
      try_req("R2 fill to 768", 256, 1, 0, 1, 0, 1);
      try_req("R2 one more stalls", 1, 1, 0, 0, 0, 0);
      clear_all();
   endtask

   task automatic t_slots();
      for (int i = 0; i < 8; i++)
         try_req($sformatf("R5 slot %0d", i), 32, 1, 0, 1, 0, i);
      check_occ("R1 full", 8);
      try_req("R1 ninth stalls", 32, 1, 0, 0, 0, 0);
      release_slot(3);
      try_req("R5 lowest free reused", 32, 1, 0, 1, 0, 3);
      clear_all();
   endtask

   task automatic t_smem();
      try_req("R4 half a", 1, 1, 8192, 1, 0, 0);
      try_req("R4 half b", 1, 1, 8192, 1, 0, 1);
      try_req("R4 one byte stalls", 1, 1, 1, 0, 0, 0);
      try_req("R4 zero bytes ok", 1, 1, 0, 1, 0, 2);
      clear_all();
   endtask

   task automatic t_release_same_cycle();
      try_req("R6 fill a", 256, 11, 0, 1, 0, 0);
      try_req("R6 fill b", 256, 11, 0, 1, 0, 1);
      @(negedge clk);
      req_valid = 1'b1;
      req_threads = 10'd256;
      req_regs_per_thread = 6'd11;
      req_smem_bytes = '0;
      done_valid = 1'b1;
      done_slot = 3'd0;
      #2;
      check("R8 held during release cycle", int'(req_grant), 0);
      check("R6 held no reject", int'(req_reject), 0);
      @(posedge clk);
      #1 done_valid = 1'b0;
      #1;
      check("R6 granted after release", int'(req_grant), 1);
      check("R6 freed slot", int'(grant_slot), 0);
      @(posedge clk);
      #1 req_valid = 1'b0;
      check_occ("R9 after swap", 2);
      release_slot(5);
      check_occ("R8 free-slot completion ignored", 2);
      try_req("R8 pools unchanged", 256, 11, 0, 0, 0, 0);
      clear_all();
   endtask

   task automatic t_reject();
      try_req("R7 zero threads", 0, 1, 0, 0, 1, 0);
      try_req("R7 513 threads", 513, 1, 0, 0, 1, 0);
      try_req("R7 regs 8704", 512, 17, 0, 0, 1, 0);
      try_req("R7 smem 16385", 1, 1, 16385, 0, 1, 0);
      check_occ("R7 nothing taken", 0);
      try_req("R3 regs exactly 8192", 512, 16, 16384, 1, 0, 0);
      clear_all();
      check_occ("R8 empty at end", 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_registers();
      t_threads();
      t_slots();
      t_smem();
      t_release_same_cycle();
      t_reject();
      if (!reported) begin
         reported = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      end
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!reported) begin
         reported = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      end
      $finish;
   end
endmodule